// File: doc/BRIEF.md
# USB Device Start-of-Frame Watchdog

This block follows frame timing on a USB device port. Every received start-of-frame packet and every low-speed keep-alive end-of-packet counts as a frame event. A 14-bit down-counter restarts from a programmable period on each frame event. If the counter runs out before the next event, the block records a timeout and, when its interrupt is enabled, sends a one-cycle interrupt pulse.

The block presents a read-only 16-bit status word. The word holds a timeout flag, a saturating count of timeouts since the last frame event, and the frame number of the most recent full-speed start-of-frame. Packet decoding, the serial engine and the processor bus connect around it and are outside this block.

Top module: `usb_frame_watchdog`

## Requirements
- R1: The status word is {flag[15], occurrence count[14:12], reserved bit 11 = 0, frame number[10:0]}. After synchronous reset every status bit is 0 and the interrupt output is 0.
- R2: A frame event is a start-of-frame pulse or an end-of-packet pulse, in either speed mode. The down-counter loads the period value on every frame event and after every timeout. With period P, a timeout is taken on the (P+1)th clock edge after the last reload, provided no frame event arrives in between. The period resets to 12000 (0x2EE0).
- R3: A write to the period value takes effect at the next reload. It does not change a countdown already in progress.
- R4: While the interrupt enable is 1, each timeout adds one to the occurrence count. The count saturates at 7.
- R5: While the interrupt enable is 1, a frame event clears both the occurrence count and the flag to 0.
- R6: While the interrupt enable is 0, the occurrence count and the flag hold their value, and no interrupt pulse is raised. Timeouts still reload the counter.
- R7: While the interrupt enable is 1, a timeout sets the flag to 1.
- R8: In full-speed mode (low-speed select = 0), a start-of-frame pulse loads its 11-bit frame number into bits 10:0. In low-speed mode the frame field is not changed.
- R9: A timeout leaves the frame field at the last frame number received.
- R10: Each timeout taken while enabled gives exactly one one-cycle interrupt pulse, registered on the timeout edge. A frame event on the same edge at which the counter is at zero takes priority: no timeout is taken, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_pulse_i | input | 1 | One-cycle pulse per received start-of-frame |
| sof_frame_i | input | 11 | Frame number carried by that start-of-frame |
| eop_pulse_i | input | 1 | One-cycle pulse per low-speed keep-alive end-of-packet |
| low_speed_i | input | 1 | 1 = low-speed mode, 0 = full-speed mode |
| tmo_irq_en_i | input | 1 | Timeout interrupt enable |
| period_we_i | input | 1 | Write strobe for the period value |
| period_data_i | input | 14 | New period value |
| status_o | output | 16 | Read-only status word |
| tmo_irq_o | output | 1 | One-cycle timeout interrupt pulse |

## Verification
All results are registered. The status word and the interrupt show the effect of a stimulus after the first rising edge that samples it. A timeout appears P+1 edges after the last reload. The bench applies inputs at the falling edge and advances a behavioural model at the rising edge. It compares the status word and the interrupt at the next falling edge, so every check falls one edge after its stimulus. A separate edge count measures the first timeout after reset, and a same-edge collision is created by waiting until the model's counter reads zero.

// File: rtl/usb_fw_pkg.sv
// Package: shared widths, the reset period and the status-word layout
// for the start-of-frame watchdog. It assumes an 11-bit frame number and a
// 16-bit status word.
package usb_fw_pkg;
    localparam int FRAME_W = 11;
    localparam int OCC_W   = 3;
    localparam int CNT_W   = 14;
    localparam logic [CNT_W-1:0] PERIOD_RST = 14'h2EE0;

    typedef struct packed {
        logic             flag;
        logic [OCC_W-1:0] occ;
        logic             rsvd;
        logic [FRAME_W-1:0] frame;
    } fw_status_t;
endpackage

// File: rtl/usb_fw_period_timer.sv
// Period timer: holds the programmable period and a down-counter that
// restarts on each frame event and after each timeout. timeout_o is
// combinational: it is high when the counter is at zero and no event is
// present. The period register changes only through writes, and a write
// is used at the next reload.
module usb_fw_period_timer #(
    parameter int               CNT_W      = 14,
    parameter logic [CNT_W-1:0] PERIOD_RST = 14'h2EE0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_i,
    input  logic             period_we_i,
    input  logic [CNT_W-1:0] period_data_i,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;

    assign timeout_o = (cnt_q == ZERO) && !event_i;

    // Purpose: hold the period value written from outside.
    always_ff @(posedge clk) begin
        if (!rst_n)           period_q <= PERIOD_RST;
        else if (period_we_i) period_q <= period_data_i;
    end

    // Purpose: count down; reload on a frame event or a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= PERIOD_RST;
        else if (event_i || timeout_o)    cnt_q <= period_q;
        else                              cnt_q <= cnt_q - ONE;
    end

    // R2: away from a reload, the counter steps down by exactly one.
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != ZERO && !event_i) |=> (cnt_q == $past(cnt_q) - ONE));

    // R10: a frame event with the counter at zero restarts it; no timeout.
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == ZERO && event_i) |-> !timeout_o);
endmodule

// File: rtl/usb_fw_status_keeper.sv
// Status keeper: keeps the timeout flag, the saturating occurrence count and
// the last frame number, and registers the interrupt pulse. It assumes that
// timeout_i is never high in the same cycle as event_i.
module usb_fw_status_keeper
    import usb_fw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               event_i,
    input  logic               sof_i,
    input  logic               low_speed_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               irq_en_i,
    input  logic               timeout_i,
    output fw_status_t         status_o,
    output logic               irq_o
);
    localparam logic [OCC_W-1:0] OCC_MAX = {OCC_W{1'b1}};
    localparam logic [OCC_W-1:0] OCC_ONE = {{(OCC_W-1){1'b0}}, 1'b1};

    logic               flag_q;
    logic [OCC_W-1:0]   occ_q;
    logic [FRAME_W-1:0] frame_q;
    logic               irq_q;

    // Purpose: set, clear or hold the flag and the occurrence count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            occ_q  <= '0;
        end else if (irq_en_i) begin
            if (event_i) begin
                flag_q <= 1'b0;
                occ_q  <= '0;
            end else if (timeout_i) begin
                flag_q <= 1'b1;
                if (occ_q != OCC_MAX) occ_q <= occ_q + OCC_ONE;
            end
        end
    end

    // Purpose: capture the frame number of a full-speed start-of-frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                    frame_q <= '0;
        else if (sof_i && !low_speed_i) frame_q <= frame_i;
    end

    // Purpose: one-cycle interrupt for each enabled timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= timeout_i && irq_en_i;
    end

    always_comb begin
        status_o.flag  = flag_q;
        status_o.occ   = occ_q;
        status_o.rsvd  = 1'b0;
        status_o.frame = frame_q;
    end
    assign irq_o = irq_q;

    // R4: the count holds at 7 on a further timeout.
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_MAX && timeout_i && irq_en_i) |=> (occ_q == OCC_MAX));

    // R5: an enabled frame event clears the count and the flag.
    a_r5_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && irq_en_i) |=> (occ_q == '0 && !flag_q));

    // R6: with the enable low, the count and the flag do not move.
    a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> ($stable(occ_q) && $stable(flag_q) && !irq_q));

    // R8: a low-speed start-of-frame does not touch the frame field.
    a_r8_low_speed_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (low_speed_i && sof_i) |=> $stable(frame_q));

    // R9: a timeout keeps the frame field.
    a_r9_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> $stable(frame_q));
endmodule

// File: rtl/usb_frame_watchdog.sv
// Top: start-of-frame watchdog for a USB device port. Either a start-of-frame
// or a keep-alive end-of-packet counts as a frame event. It assumes
// one-cycle input pulses that are synchronous to clk.
module usb_frame_watchdog
    import usb_fw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_pulse_i,
    input  logic [FRAME_W-1:0] sof_frame_i,
    input  logic               eop_pulse_i,
    input  logic               low_speed_i,
    input  logic               tmo_irq_en_i,
    input  logic               period_we_i,
    input  logic [CNT_W-1:0]   period_data_i,
    output logic [15:0]        status_o,
    output logic               tmo_irq_o
);
    logic       frame_evt;
    logic       timeout;
    fw_status_t status;

    assign frame_evt = sof_pulse_i || eop_pulse_i;

    usb_fw_period_timer #(
        .CNT_W      (CNT_W),
        .PERIOD_RST (PERIOD_RST)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_i       (frame_evt),
        .period_we_i   (period_we_i),
        .period_data_i (period_data_i),
        .timeout_o     (timeout)
    );

    usb_fw_status_keeper u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_i     (frame_evt),
        .sof_i       (sof_pulse_i),
        .low_speed_i (low_speed_i),
        .frame_i     (sof_frame_i),
        .irq_en_i    (tmo_irq_en_i),
        .timeout_i   (timeout),
        .status_o    (status),
        .irq_o       (tmo_irq_o)
    );

    assign status_o = status;

    // R7/R10: an interrupt pulse always comes with the flag set.
    a_r7_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq_o |-> status_o[15]);

    // R1: the reserved bit reads 0 after any edge out of reset.
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !status_o[11]);
endmodule

// File: tb/usb_frame_watchdog_bench.sv
// Bench: a behavioural reference model is advanced on each rising edge and
// compared with the design on each falling edge.
module usb_frame_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, eop = 1'b0, ls = 1'b0, en = 1'b0, we = 1'b0;
    logic [10:0] frm = '0;
    logic [13:0] pdata = '0;
    logic [15:0] status;
    logic        irq;

    int tests = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    int m_cnt = 12000, m_period = 12000, m_flag = 0, m_occ = 0, m_frame = 0, m_irq = 0;
    int irq_seen = 0;

    always #5 clk = ~clk;

    usb_frame_watchdog u_usb_frame_watchdog (
        .clk(clk), .rst_n(rst_n), .sof_pulse_i(sof), .sof_frame_i(frm),
        .eop_pulse_i(eop), .low_speed_i(ls), .tmo_irq_en_i(en),
        .period_we_i(we), .period_data_i(pdata),
        .status_o(status), .tmo_irq_o(irq));

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: model step at the rising edge, compare at the falling edge.
    task automatic step();
        bit evt, tmo;
        @(posedge clk);
        evt = sof || eop;
        tmo = !evt && (m_cnt == 0);
        m_irq = (tmo && en) ? 1 : 0;
        if (en) begin
            if (evt) begin m_occ = 0; m_flag = 0; end
            else if (tmo) begin m_flag = 1; if (m_occ < 7) m_occ++; end
        end
        if (sof && !ls) m_frame = frm;
        if (evt || tmo) m_cnt = m_period; else m_cnt--;
        if (we) m_period = pdata;
        @(negedge clk);
        if (irq) irq_seen++;
        check({cur_req, " status"}, status,
              (m_flag << 15) | (m_occ << 12) | m_frame);
        check({cur_req, " irq"}, irq, m_irq);
        sof = 0; eop = 0; we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send_sof(int f);
        frm = f[10:0]; sof = 1; step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int edges;
        @(negedge clk); @(negedge clk);
        check("R1 reset status", status, 0);
        check("R1 reset irq", irq, 0);
        rst_n = 1; en = 1;
        // R2: first timeout after reset, default period 12000
        cur_req = "R2";
        edges = 0;
        while (irq_seen == 0 && edges < 13000) begin step(); edges++; end
        check("R2 default period edges", edges, 12001);
        check("R7 flag after timeout", status[15], 1);
        check("R4 count one", status[14:12], 1);
        // R3: write period mid-countdown, used at next reload
        cur_req = "R3";
        idle(5);
        pdata = 14'd20; we = 1; step();
        idle(30);
        // R5: frame event clears
        cur_req = "R5";
        send_sof(11'h123);
        check("R5 cleared", status[15:12], 0);
        check("R8 full-speed frame", status[10:0], 11'h123);
        // R4: saturation across many timeouts
        cur_req = "R4";
        idle(21 * 10);
        check("R4 saturated", status[14:12], 7);
        check("R9 frame kept", status[10:0], 11'h123);
        // R6: enable low holds
        cur_req = "R6";
        en = 0;
        eop = 1; step();
        check("R6 hold after event", status[15:12], 4'hF);
        idle(50);
        // R8: low-speed sof leaves frame, still counts as event
        cur_req = "R8";
        en = 1; ls = 1;
        send_sof(11'h055);
        check("R8 low-speed frame", status[10:0], 11'h123);
        eop = 1; step();
        idle(45);
        ls = 0;
        send_sof(11'h7FF);
        check("R8 frame 7FF", status[10:0], 11'h7FF);
        // R10: collision of event with counter at zero
        cur_req = "R10";
        while (m_cnt != 0) step();
        send_sof(11'h001);
        check("R10 event wins irq", irq, 0);
        check("R10 event wins flag", status[15], 0);
        idle(30);
        // period zero: timeout every edge
        cur_req = "R2";
        pdata = 14'd0; we = 1; step();
        idle(30);
        pdata = 14'd3; we = 1; step();
        idle(20);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule